// File: doc/BRIEF.md
# Iterative Shift-Subtract Integer Divider

A multicycle integer divider that produces one quotient bit per clock. A single-cycle `start` pulse loads a dividend and a divisor, and a 6-bit extended-opcode input chooses between unsigned and signed interpretation of the operands. The block then runs a restoring shift-and-subtract loop over a register that holds both the dividend and the quotient. After the loop it applies the quotient sign, drives the quotient and raises `done` for exactly one clock.

For signed work the block does not use a separate datapath. It loads the absolute values of both operands and runs the same unsigned loop. The sign flag it records is the XOR of the two operand sign bits, and the result is negated after the last iteration when that flag is set. A zero divisor does not stall the block: the compare succeeds on every step, so the unsigned quotient comes out as all ones. The result stays on `quotient` until the next operation completes.

Top module: `iter_divider`

## Requirements
- R1: An `opx` value of 0x25 selects signed division. An `opx` value of 0x24, and any other value, selects unsigned division.
- R2: For unsigned division with a nonzero divisor, `quotient` equals the floor of src1 / src2, with both operands taken as unsigned 32-bit numbers.
- R3: For signed division with a nonzero divisor, the quotient magnitude is |src1| / |src2|. The quotient is negative exactly when the XOR of the two operand sign bits (bit 31) is 1, so the result truncates toward zero.
- R4: Signed division of 0x80000000 by 0xFFFFFFFF (-1) returns 0x80000000, the two's-complement wrap.
- R5: With src2 = 0, unsigned division returns 0xFFFFFFFF. Signed division returns 0xFFFFFFFF when src1 is non-negative and 0x00000001 when src1 is negative. The block always completes.
- R6: `done` is high for exactly one cycle. It rises after the 33rd rising edge that follows the edge sampling `start` (W+1 edges for width W). `quotient` is valid in that same cycle.
- R7: A `start` pulse that arrives while an operation is in progress is ignored. The running operation finishes with its own result, and no extra `done` follows.
- R8: After reset, `done` is 0 and `quotient` is 0.
- R9: `quotient` holds its value from one `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin; honoured only when idle |
| opx | input | 6 | Extended opcode: 0x25 signed, otherwise unsigned |
| src1 | input | 32 | Dividend |
| src2 | input | 32 | Divisor |
| quotient | output | 32 | Result, held until the next completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The corners that are hardest to reach from the ports are the ones where the shifted remainder overflows the data width: divisors at or above half the range, and the zero divisor where the subtract never reduces the remainder. A 6-bit instance is swept over every dividend, divisor and signedness pair, so every overflow and sign combination occurs. The 32-bit instance receives directed extremes (the minimum-value / -1 wrap, all-ones divisors) and a pseudo-random stream from a bench LFSR. A start pulse injected mid-run checks that the running operation is not disturbed.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;
endpackage

// File: rtl/divq_operand_prep.sv
module divq_operand_prep #(
   parameter int                 W             = 32,
   parameter int                 OPX_W         = 6,
   parameter logic [OPX_W-1:0]   OPC_SIGNED    = 'h25,
   parameter bit                 ENABLE_SIGNED = 1'b1
) (
   input  logic [OPX_W-1:0] opx,
   input  logic [W-1:0]     a_in,
   input  logic [W-1:0]     b_in,
   output logic [W-1:0]     a_mag,
   output logic [W-1:0]     b_mag,
   output logic             neg
);
   generate
      if (ENABLE_SIGNED) begin : g_signed
         logic is_signed, a_neg, b_neg;
         assign is_signed = (opx == OPC_SIGNED);
         assign a_neg     = is_signed & a_in[W-1];
         assign b_neg     = is_signed & b_in[W-1];
         assign a_mag     = a_neg ? (~a_in + 1'b1) : a_in;
         assign b_mag     = b_neg ? (~b_in + 1'b1) : b_in;
         assign neg       = a_neg ^ b_neg;
      end else begin : g_unsigned_only
         logic unused_opx;
         assign unused_opx = ^opx;
         assign a_mag      = a_in;
         assign b_mag      = b_in;
         assign neg        = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/divq_step.sv
module divq_step #(
   parameter int W = 32
) (
   input  logic [W-1:0] rem_in,
   input  logic [W-1:0] rq_in,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] rem_out,
   output logic [W-1:0] rq_out
);
   localparam int WX = W + 1;

   logic [WX-1:0] rem_sh;
   logic [WX-1:0] diff;
   logic          ge;

   assign rem_sh  = {rem_in, rq_in[W-1]};
   assign diff    = rem_sh - {1'b0, dvs};
   assign ge      = (rem_sh >= {1'b0, dvs});
   assign rem_out = ge ? diff[W-1:0] : rem_sh[W-1:0];
   assign rq_out  = {rq_in[W-2:0], ge};
endmodule

// File: rtl/divq_sign_fix.sv
module divq_sign_fix #(
   parameter int W = 32
) (
   input  logic [W-1:0] q_in,
   input  logic         neg,
   output logic [W-1:0] q_out
);
   assign q_out = neg ? (~q_in + 1'b1) : q_in;
endmodule

// File: rtl/iter_divider.sv
module iter_divider
   import div_pkg::*;
#(
   parameter int                 W             = 32,
   parameter int                 OPX_W         = 6,
   parameter logic [OPX_W-1:0]   OPC_SIGNED    = 'h25,
   parameter bit                 ENABLE_SIGNED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPX_W-1:0] opx,
   input  logic [W-1:0]     src1,
   input  logic [W-1:0]     src2,
   output logic [W-1:0]     quotient,
   output logic             done
);
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("iter_divider: W must be at least 2");
      end
      if (OPX_W < 1) begin : g_bad_opx
         $error("iter_divider: OPX_W must be at least 1");
      end
   endgenerate

   div_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  rq_q, rem_q, dvs_q, quot_q;
   logic          neg_q, done_q;

   logic [W-1:0]  a_mag, b_mag, rq_n, rem_n, q_fixed;
   logic          neg_n;

   divq_operand_prep #(
      .W(W), .OPX_W(OPX_W), .OPC_SIGNED(OPC_SIGNED), .ENABLE_SIGNED(ENABLE_SIGNED)
   ) u_prep (
      .opx(opx), .a_in(src1), .b_in(src2),
      .a_mag(a_mag), .b_mag(b_mag), .neg(neg_n)
   );

   divq_step #(.W(W)) u_step (
      .rem_in(rem_q), .rq_in(rq_q), .dvs(dvs_q),
      .rem_out(rem_n), .rq_out(rq_n)
   );

   divq_sign_fix #(.W(W)) u_fix (
      .q_in(rq_q), .neg(neg_q), .q_out(q_fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rq_q    <= '0;
         rem_q   <= '0;
         dvs_q   <= '0;
         neg_q   <= 1'b0;
         quot_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  rq_q    <= a_mag;
                  dvs_q   <= b_mag;
                  rem_q   <= '0;
                  neg_q   <= neg_n;
                  cnt_q   <= CW'(W);
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               rq_q  <= rq_n;
               rem_q <= rem_n;
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) state_q <= ST_FIX;
            end
            ST_FIX: begin
               quot_q  <= q_fixed;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign quotient = quot_q;
   assign done     = done_q;

   // R6: completion is a single-cycle pulse
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: a start during a run leaves the loaded divisor and sign untouched
   assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != ST_IDLE) |=> ($stable(dvs_q) && $stable(neg_q)));

   // R1: any opcode other than the signed one loads a clear sign flag
   assert_unsigned_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q == ST_IDLE && opx != OPC_SIGNED) |=> !neg_q);

   // R2: restoring invariant, partial remainder stays below a nonzero divisor
   assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && dvs_q != '0) |-> (rem_q < dvs_q));

   // R6: iteration counter never exceeds the width and is nonzero while running
   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (cnt_q != '0 && cnt_q <= CW'(W)));
endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
   localparam int WB = 32;
   localparam int WS = 6;
   localparam logic [5:0] OP_U = 6'h24;
   localparam logic [5:0] OP_S = 6'h25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          start, start_s;
   logic [5:0]    opx, opx_s;
   logic [WB-1:0] src1, src2, quot;
   logic [WS-1:0] s1_s, s2_s, quot_s;
   logic          done, done_s;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   iter_divider #(.W(WB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opx(opx),
      .src1(src1), .src2(src2), .quotient(quot), .done(done));

   iter_divider #(.W(WS)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .start(start_s), .opx(opx_s),
      .src1(s1_s), .src2(s2_s), .quotient(quot_s), .done(done_s));

   function automatic logic [63:0] model(int w, bit sgn, logic [63:0] a, logic [63:0] b);
      logic [63:0] mask, ma, mb, q;
      bit na, nb;
      mask = (64'd1 << w) - 64'd1;
      na = sgn && a[w-1];
      nb = sgn && b[w-1];
      ma = na ? ((~a + 64'd1) & mask) : (a & mask);
      mb = nb ? ((~b + 64'd1) & mask) : (b & mask);
      q  = (mb == 0) ? mask : (ma / mb);
      if (na ^ nb) q = (~q + 64'd1) & mask;
      return q & mask;
   endfunction

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic run_big(string req, logic [5:0] op, logic [WB-1:0] a, logic [WB-1:0] b,
                          bit chk_lat);
      int lat;
      bit sgn;
      sgn = (op == OP_S);
      opx = op; src1 = a; src2 = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 80) begin @(negedge clk); lat++; end
      check(req, {32'd0, quot}, model(WB, sgn, {32'd0, a}, {32'd0, b}));
      if (chk_lat) begin
         check("R6 latency", lat, WB + 2);
         @(negedge clk);
         check("R6 single pulse", done, 1'b0);
      end else begin
         @(negedge clk);
      end
   endtask

   task automatic run_small(bit sgn, int a, int b);
      int lat;
      opx_s = sgn ? OP_S : OP_U; s1_s = a[WS-1:0]; s2_s = b[WS-1:0]; start_s = 1'b1;
      @(negedge clk);
      start_s = 1'b0;
      lat = 1;
      while (!done_s && lat < 40) begin @(negedge clk); lat++; end
      check(sgn ? "R3 sweep signed" : "R2 sweep unsigned", {58'd0, quot_s},
            model(WS, sgn, 64'(a), 64'(b)));
      if (lat != WS + 2) check("R6 small latency", lat, WS + 2);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      int lat;
      start = 0; start_s = 0; opx = OP_U; opx_s = OP_U;
      src1 = 0; src2 = 0; s1_s = 0; s2_s = 0;
      repeat (3) @(negedge clk);
      check("R8 reset done", done, 1'b0);
      check("R8 reset quotient", quot, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R3 directed
      run_big("R2 43/7", OP_U, 32'd43, 32'd7, 1'b1);
      run_big("R2 max/1", OP_U, 32'hFFFFFFFF, 32'd1, 1'b1);
      run_big("R2 large divisor", OP_U, 32'hFFFFFFFF, 32'h80000001, 1'b0);
      run_big("R2 max/max", OP_U, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
      run_big("R2 small/large", OP_U, 32'd5, 32'hF0000000, 1'b0);
      run_big("R3 -7/2", OP_S, 32'hFFFFFFF9, 32'd2, 1'b1);
      run_big("R3 7/-2", OP_S, 32'd7, 32'hFFFFFFFE, 1'b0);
      run_big("R3 -7/-2", OP_S, 32'hFFFFFFF9, 32'hFFFFFFFE, 1'b0);
      run_big("R1 0x24 treats -8 as unsigned", OP_U, 32'hFFFFFFF8, 32'd2, 1'b0);
      check("R1 unsigned value", quot, 32'h7FFFFFFC);
      run_big("R1 opx 0x3F unsigned", 6'h3F, 32'hFFFFFFF8, 32'd2, 1'b0);
      check("R1 other opcode value", quot, 32'h7FFFFFFC);
      run_big("R1 signed 0x25", OP_S, 32'hFFFFFFF8, 32'd2, 1'b0);
      check("R1 signed value", quot, 32'hFFFFFFFC);
      run_big("R4 wrap", OP_S, 32'h80000000, 32'hFFFFFFFF, 1'b0);
      check("R4 wrap value", quot, 32'h80000000);
      run_big("R5 u/0", OP_U, 32'd1234, 32'd0, 1'b1);
      check("R5 unsigned zero divisor", quot, 32'hFFFFFFFF);
      run_big("R5 s pos/0", OP_S, 32'd99, 32'd0, 1'b0);
      check("R5 signed pos zero divisor", quot, 32'hFFFFFFFF);
      run_big("R5 s neg/0", OP_S, 32'hFFFFFF00, 32'd0, 1'b0);
      check("R5 signed neg zero divisor", quot, 32'h00000001);

      // R7: start mid-run with other operands is ignored
      opx = OP_U; src1 = 32'd1000; src2 = 32'd10; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      opx = OP_S; src1 = 32'hFFFFFF00; src2 = 32'd3; start = 1'b1;
      @(negedge clk); start = 1'b0;
      lat = 7;
      while (!done && lat < 80) begin @(negedge clk); lat++; end
      check("R7 result of first op", quot, 32'd100);
      check("R7 first op timing", lat, WB + 2);
      lat = 0;
      for (int i = 0; i < 45; i++) begin @(negedge clk); if (done) lat++; end
      check("R7 no extra done", lat, 0);
      check("R9 quotient held", quot, 32'd100);

      // R2/R3 pseudo-random
      lfsr = 32'hACE1_1234;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, b;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         b = lfsr >> (lfsr[4:0]);
         run_big((i % 2) ? "R3 random signed" : "R2 random unsigned",
                 (i % 2) ? OP_S : OP_U, a, b, 1'b0);
      end

      // exhaustive sweep of the small instance
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < (1 << WS); a++)
            for (int b = 0; b < (1 << WS); b++)
               run_small(s[0], a, b);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule